// File: doc/BRIEF.md
# Multiplier Contention Interlock Controller

This block decides, cycle by cycle, whether the decode stage of a single-issue in-order pipeline may issue the instruction in front of it when that instruction, or one already in flight, uses the shared multiplier. Decode presents a 4-bit instruction class and a valid flag. The block looks up that class's execution slots, result latency and lock slots, and answers in the same cycle with a stall request.

Three independent down-counters hold the state. The first counts the execution slots that keep decode occupied. The second counts the lock slots during which no other multiplier instruction may start. The third counts the latency until the accumulator pair written by the most recent writer becomes readable. A pulse marks each multiplier issue, and a level flag shows that the accumulator result is available. Arithmetic, register contents and all hazards that do not involve the multiplier are outside this block.

Top module: `mul_interlock`

## Requirements
- R1: After synchronous active-high reset, all three counters are zero: `dec_stall` is low and `res_ready` is high.
- R2: Class codes and their (execution slots / latency / lock slots) are: 1 = 32-bit accumulate (4/6/5), 2 = 16-bit accumulate (3/5/4), 3 = 32-bit or double-length multiply (2/3/2), 4 = 16-bit multiply (1/2/1), 5 = multiply with general-register return (2/4/2), 6 = accumulator clear or load from register (1/2/1), 7 = accumulator load from memory (1/3/2), 8 = accumulator read (1/2/0). `mul_start` is high in exactly the cycles in which a valid instruction of class 1 to 8 issues without stall.
- R3: After an instruction with E execution slots issues in cycle c, every valid instruction of any class is stalled in cycles c+1 to c+E-1.
- R4: After an instruction with L lock slots issues in cycle c, a valid instruction of classes 1 to 7 is stalled until cycle c+L.
- R5: A class 8 read is stalled until cycle c+N, where N is the latency of the most recent instruction of classes 1, 2, 3, 4, 6 or 7 that issued in cycle c. It is not stalled by the lock counter.
- R6: Class 5 writes a general register, so it neither delays a later class 8 read beyond its execution slots nor lowers `res_ready`.
- R7: Class 0 and the unknown codes 9 to 15 never raise `mul_start` and stall only during the execution slots of R3.
- R8: While `dec_valid` is low, `dec_stall` and `mul_start` stay low, and all counters keep counting down.
- R9: `res_ready` is low from the cycle after an accumulator writer issues in cycle c until cycle c+N-1, and is high again from cycle c+N.
- R10: Two back-to-back 32-bit accumulates issue exactly 5 cycles apart, because the lock (5) outlasts the execution slots (4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode holds a valid instruction |
| dec_class | input | 4 | Instruction class code of the decode instruction |
| dec_stall | output | 1 | Combinational request to hold decode this cycle |
| mul_start | output | 1 | Pulse: a multiplier instruction issues this cycle |
| res_ready | output | 1 | Accumulator result from the last writer is available |

## Verification
The hardest case to reach is the one where the three timers disagree about how long to wait. One example is a read that follows an accumulator writer whose lock has already expired but whose latency has not. Another is a read after a register-return multiply, where the latency counter must stay clear even though the execution counter is holding decode. The bench reaches these by issuing writer and reader pairs with controlled idle gaps, so that each counter in turn is the one that decides. It then compares the stall count for every instruction against hand-derived waits and against a per-cycle issue-time model built from the class table.

// File: rtl/mi_pkg.sv
package mi_pkg;

    localparam int CLS_W = 4;
    localparam int CNT_W = 3;
    localparam int N_TMR = 3;

    localparam int TMR_EX = 0;
    localparam int TMR_LK = 1;
    localparam int TMR_LT = 2;

    localparam logic [CLS_W-1:0] CL_NONE   = 4'd0;
    localparam logic [CLS_W-1:0] CL_MAC32  = 4'd1;
    localparam logic [CLS_W-1:0] CL_MAC16  = 4'd2;
    localparam logic [CLS_W-1:0] CL_MUL32  = 4'd3;
    localparam logic [CLS_W-1:0] CL_MUL16  = 4'd4;
    localparam logic [CLS_W-1:0] CL_MULREG = 4'd5;
    localparam logic [CLS_W-1:0] CL_ACCSET = 4'd6;
    localparam logic [CLS_W-1:0] CL_ACCLDM = 4'd7;
    localparam logic [CLS_W-1:0] CL_ACCRD  = 4'd8;

    typedef struct packed {
        logic             uses;
        logic             is_read;
        logic             wr_acc;
        logic [CNT_W-1:0] ex;
        logic [CNT_W-1:0] lat;
        logic [CNT_W-1:0] lk;
    } mi_timing_t;

    function automatic mi_timing_t mi_mk(input logic rd, input logic wr,
                                         input int e, input int n, input int l);
        mi_timing_t t;
        t.uses    = 1'b1;
        t.is_read = rd;
        t.wr_acc  = wr;
        t.ex      = CNT_W'(e);
        t.lat     = CNT_W'(n);
        t.lk      = CNT_W'(l);
        return t;
    endfunction

    function automatic mi_timing_t mi_lookup(input logic [CLS_W-1:0] c);
        mi_timing_t t;
        t = '0;
        case (c)
            CL_MAC32:  t = mi_mk(1'b0, 1'b1, 4, 6, 5);
            CL_MAC16:  t = mi_mk(1'b0, 1'b1, 3, 5, 4);
            CL_MUL32:  t = mi_mk(1'b0, 1'b1, 2, 3, 2);
            CL_MUL16:  t = mi_mk(1'b0, 1'b1, 1, 2, 1);
            CL_MULREG: t = mi_mk(1'b0, 1'b0, 2, 4, 2);
            CL_ACCSET: t = mi_mk(1'b0, 1'b1, 1, 2, 1);
            CL_ACCLDM: t = mi_mk(1'b0, 1'b1, 1, 3, 2);
            CL_ACCRD:  t = mi_mk(1'b1, 1'b0, 1, 2, 0);
            default:   t = '0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/mi_class_decode.sv
module mi_class_decode
    import mi_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output mi_timing_t       timing
);
    always_comb begin
        timing = mi_lookup(cls);
    end
endmodule

// File: rtl/mi_timer.sv
module mi_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/mul_interlock.sv
module mul_interlock
    import mi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [CLS_W-1:0] dec_class,
    output logic             dec_stall,
    output logic             mul_start,
    output logic             res_ready
);
    typedef struct packed {
        logic hold;
        logic lock_block;
        logic lat_block;
        logic stall;
        logic issue;
    } ctl_t;

    mi_timing_t       tm;
    ctl_t             ctl_d;
    logic [CNT_W-1:0] cnt_arr  [N_TMR];
    logic [CNT_W-1:0] ld_val   [N_TMR];
    logic             ld_en    [N_TMR];
    logic [CNT_W-1:0] ex_cnt, lk_cnt, lt_cnt;

    mi_class_decode u_dec (
        .cls    (dec_class),
        .timing (tm)
    );

    assign ex_cnt = cnt_arr[TMR_EX];
    assign lk_cnt = cnt_arr[TMR_LK];
    assign lt_cnt = cnt_arr[TMR_LT];

    always_comb begin
        ctl_d            = '0;
        ctl_d.hold       = (ex_cnt != '0);
        ctl_d.lock_block = tm.uses && !tm.is_read && (lk_cnt != '0);
        ctl_d.lat_block  = tm.is_read && (lt_cnt != '0);
        ctl_d.stall      = dec_valid && (ctl_d.hold || ctl_d.lock_block || ctl_d.lat_block);
        ctl_d.issue      = dec_valid && tm.uses && !ctl_d.stall;

        ld_en[TMR_EX]  = ctl_d.issue && (tm.ex != '0);
        ld_val[TMR_EX] = tm.ex - CNT_W'(1);
        ld_en[TMR_LK]  = ctl_d.issue && (tm.lk != '0);
        ld_val[TMR_LK] = tm.lk - CNT_W'(1);
        ld_en[TMR_LT]  = ctl_d.issue && tm.wr_acc;
        ld_val[TMR_LT] = tm.lat - CNT_W'(1);
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        mi_timer #(.W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .load     (ld_en[g]),
            .load_val (ld_val[g]),
            .cnt      (cnt_arr[g])
        );
    end

    assign dec_stall = ctl_d.stall;
    assign mul_start = ctl_d.issue;
    assign res_ready = (lt_cnt == '0);
endmodule

// File: rtl/mi_checker.sv
module mi_checker
    import mi_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             dec_valid,
    input logic [CLS_W-1:0] dec_class,
    input logic             dec_stall,
    input logic             mul_start,
    input logic             res_ready,
    input logic [CNT_W-1:0] ex_cnt,
    input logic [CNT_W-1:0] lk_cnt,
    input logic [CNT_W-1:0] lt_cnt
);
    mi_timing_t ct;
    always_comb ct = mi_lookup(dec_class);

    // R2: a start pulse only for an unstalled valid multiplier instruction
    a_r2_start_legal: assert property (@(posedge clk) disable iff (rst)
        mul_start |-> (dec_valid && !dec_stall && ct.uses));

    // R3: execution slots hold every valid instruction
    a_r3_exec_hold: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && ex_cnt != '0) |-> dec_stall);

    // R4: lock slots hold non-read multiplier instructions
    a_r4_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && ct.uses && !ct.is_read && lk_cnt != '0) |-> dec_stall);

    // R5: a read never issues while the latency counter runs
    a_r5_read_waits: assert property (@(posedge clk) disable iff (rst)
        (mul_start && ct.is_read) |-> (lt_cnt == '0));

    // R8: no stall or start without a valid instruction
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!dec_stall && !mul_start));

    // R9: an accumulator writer makes the result unavailable next cycle
    a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (mul_start && ct.wr_acc) |=> !res_ready);

    // R7: unknown codes never start the multiplier
    a_r7_unknown_no_start: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_class > CL_ACCRD) |-> !mul_start);
endmodule

bind mul_interlock mi_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .dec_class (dec_class),
    .dec_stall (dec_stall),
    .mul_start (mul_start),
    .res_ready (res_ready),
    .ex_cnt    (ex_cnt),
    .lk_cnt    (lk_cnt),
    .lt_cnt    (lt_cnt)
);

// File: tb/mul_interlock_tb.sv
module mul_interlock_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_valid = 1'b0;
    logic [3:0] dec_class = 4'd0;
    logic       dec_stall, mul_start, res_ready;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int ok_any = 0, ok_lock = 0, ok_lat = 0;

    always #5 clk = ~clk;

    mul_interlock u_dut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
        .dec_stall(dec_stall), .mul_start(mul_start), .res_ready(res_ready)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    // timing table written from the requirements: e, n, l, uses, read, writes acc
    task automatic tbl(input int c, output int e, output int n, output int l,
                       output bit u, output bit rd, output bit wr);
        e = 0; n = 0; l = 0; u = 0; rd = 0; wr = 0;
        case (c)
            1: begin e = 4; n = 6; l = 5; u = 1; wr = 1; end
            2: begin e = 3; n = 5; l = 4; u = 1; wr = 1; end
            3: begin e = 2; n = 3; l = 2; u = 1; wr = 1; end
            4: begin e = 1; n = 2; l = 1; u = 1; wr = 1; end
            5: begin e = 2; n = 4; l = 2; u = 1; end
            6: begin e = 1; n = 2; l = 1; u = 1; wr = 1; end
            7: begin e = 1; n = 3; l = 2; u = 1; wr = 1; end
            8: begin e = 1; n = 2; l = 0; u = 1; rd = 1; end
            default: ;
        endcase
    endtask

    // one cycle: drive, check outputs, advance model; returns whether it issued
    task automatic step(input bit v, input int c, input string tag, output bit issued);
        int e, n, l; bit u, rd, wr, xs, xm;
        tbl(c, e, n, l, u, rd, wr);
        dec_valid = v;
        dec_class = 4'(c);
        #1;
        xs = v && ((cyc < ok_any) || (u && !rd && cyc < ok_lock) || (rd && cyc < ok_lat));
        xm = v && u && !xs;
        chk(tag, "dec_stall", int'(dec_stall), int'(xs));
        chk(tag, "mul_start", int'(mul_start), int'(xm));
        chk(tag, "res_ready", int'(res_ready), int'(cyc >= ok_lat));
        issued = v && !xs;
        if (xm) begin
            ok_any = cyc + e;
            if (cyc + l > ok_lock) ok_lock = cyc + l;
            if (wr) ok_lat = cyc + n;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic issue(input int c, input string tag, input int exp_wait);
        bit done; int waits;
        waits = 0;
        done  = 0;
        while (!done) begin
            step(1'b1, c, tag, done);
            if (!done) waits++;
        end
        chk(tag, "stall cycles", waits, exp_wait);
        dec_valid = 1'b0;
    endtask

    task automatic gap(input int n, input string tag);
        bit d;
        for (int i = 0; i < n; i++) step(1'b0, 0, tag, d);
    endtask

    task automatic t_reset;
        #1;
        chk("R1", "dec_stall", int'(dec_stall), 0);
        chk("R1", "res_ready", int'(res_ready), 1);
        issue(4, "R1", 0);
        gap(3, "R1");
    endtask

    task automatic t_mac32_pair;   // R10: five cycles apart
        issue(1, "R10", 0);
        issue(1, "R10", 4);
        gap(7, "R9");
    endtask

    task automatic t_lock_vs_exec; // R4
        issue(2, "R4", 0);
        issue(3, "R4", 3);
        issue(4, "R4", 1);
        gap(4, "R4");
        issue(7, "R4", 0);
        issue(4, "R4", 1);
        gap(3, "R4");
    endtask

    task automatic t_read_latency; // R5 and R9
        issue(1, "R5", 0);
        issue(8, "R5", 5);
        issue(6, "R5", 0);
        issue(8, "R5", 1);
        issue(7, "R9", 0);
        issue(8, "R9", 2);
        gap(2, "R5");
        issue(1, "R5", 0);
        gap(6, "R8");
        issue(8, "R8", 0);
    endtask

    task automatic t_regreturn;    // R6
        gap(3, "R6");
        issue(5, "R6", 0);
        issue(8, "R6", 1);
        chk("R6", "res_ready", int'(res_ready), 1);
        gap(2, "R6");
    endtask

    task automatic t_nonmul;       // R7 and R3
        issue(0, "R7", 0);
        issue(12, "R7", 0);
        issue(2, "R3", 0);
        issue(0, "R3", 2);
        issue(15, "R7", 0);
        issue(1, "R3", 0);
        issue(9, "R3", 3);
        gap(6, "R7");
        issue(8, "R2", 0);
        issue(1, "R2", 0);
        gap(8, "R2");
    endtask

    task automatic t_mixed;        // R2 and R3 over a longer mix
        int seq[12] = '{1, 4, 8, 3, 0, 5, 6, 8, 2, 7, 11, 8};
        bit d;
        foreach (seq[i]) begin
            d = 0;
            while (!d) step(1'b1, seq[i], "R2", d);
        end
        dec_valid = 1'b0;
        gap(8, "R2");
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        t_reset;
        t_mac32_pair;
        t_lock_vs_exec;
        t_read_latency;
        t_regreturn;
        t_nonmul;
        t_mixed;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule